// File: doc/BRIEF.md
# MIDI Host Port Controller

This block is the processor-facing side of a legacy MIDI port. A pair of configuration registers sets a 16-bit I/O base address, and a third holds an enable flag. Once enabled, the block answers two I/O addresses. The even one carries MIDI data in both directions. The odd one returns a status byte when read and accepts a command byte when written. Outgoing bytes are queued in a transmit FIFO and incoming bytes in a receive FIFO, and both work at the same time. The serial shifter sits outside this block and is reached through plain byte valid/ready handshakes.

Two commands are recognised. One switches the port into UART mode, and the other resets the port. Each of them queues a one-byte acknowledge. That acknowledge always reaches the host before any receive data already waiting. The reset command also empties the receive FIFO before it queues the acknowledge. An interrupt line stays high while the block is enabled and the host has a byte to read.

Top module: `midi_host_port`

## Requirements
- R1: Configuration index 0x60 holds base address bits 15:8, index 0x61 holds bits 7:0, and bit 0 of index 0x30 is the enable flag. Bit 0 of the programmed base is ignored. After reset the base is 0x0330 and the enable flag is 0.
- R2: While enabled, an access whose address bits 15:1 match the base is decoded. Offset 0 is the data port and offset 1 is the command/status port. Any other access reads 0xFF, and writes to any other address are ignored.
- R3: While the enable flag is 0, nothing is decoded, so every read returns 0xFF. The irq output is held low during this time.
- R4: Reading the status port returns a byte in which bit 7 is 0 when an acknowledge or receive byte is waiting, bit 6 is 0 when the transmit FIFO has room, and bits 5:0 are all 1.
- R5: Command 0x3F enters UART mode and queues acknowledge byte 0xFE. Command 0xFF leaves UART mode and also queues 0xFE. Any other command has no effect.
- R6: A pending acknowledge is returned by the next data-port read, ahead of any receive bytes already buffered. Those bytes then follow in arrival order.
- R7: Command 0xFF empties the receive FIFO. The read after its acknowledge then finds no data.
- R8: In UART mode, received bytes enter a 16-entry FIFO, and rx_ready drops while that FIFO is full. Outside UART mode rx_ready is 1 and received bytes are discarded.
- R9: A data-port write appends to a 16-entry transmit FIFO. The FIFO is drained in order through tx_byte/tx_valid/tx_ready. A write made while the FIFO is full is dropped.
- R10: irq is high exactly when the block is enabled and a byte (acknowledge or receive data) is waiting to be read.
- R11: A data-port read with nothing waiting returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Host read strobe; the read data pops on the clock edge |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, valid while io_rd is high |
| irq | output | 1 | Read-data-ready interrupt |
| tx_byte | output | 8 | Byte sent to the serial shifter |
| tx_valid | output | 1 | tx_byte holds a queued byte |
| tx_ready | input | 1 | Shifter takes tx_byte |
| rx_byte | input | 8 | Byte from the serial shifter |
| rx_valid | input | 1 | rx_byte is valid |
| rx_ready | output | 1 | Block can take rx_byte |

## Verification
The read path is tested with three kinds of sequence. In the first, an acknowledge arrives while received bytes are already buffered, which shows whether the acknowledge is injected ahead of the FIFO or queued behind it. In the second, a reset command follows buffered bytes, which shows whether the FIFO is flushed or kept. In the third, bytes arrive outside UART mode, which shows whether they are dropped or stored. Relocating the base to an odd value and probing the old address shows that bit 0 is masked and that the old address no longer decodes. Filling each FIFO to one past its depth shows the drop and back-pressure edges.

// File: rtl/midi_host_pkg.sv
package midi_host_pkg;
  localparam logic [7:0] ACK_BYTE  = 8'hFE;
  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_UART  = 8'h3F;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_ENABLE  = 8'h30;

  // Bit 7 low: read byte waiting; bit 6 low: transmit room; others high.
  function automatic logic [7:0] status_byte(input logic avail, input logic tx_full);
    return {~avail, tx_full, 6'b111111};
  endfunction

  // Even-aligned two-address window match.
  function automatic logic window_hit(input logic [15:0] base, input logic [15:0] addr);
    return base[15:1] == addr[15:1];
  endfunction
endpackage

// File: rtl/midi_addr_decode.sv
module midi_addr_decode
  import midi_host_pkg::*;
(
  input  logic        active,
  input  logic [15:0] base,
  input  logic [15:0] addr,
  input  logic        rd,
  input  logic        wr,
  output logic        data_rd,
  output logic        data_wr,
  output logic        stat_rd,
  output logic        cmd_wr
);
  logic hit;
  assign hit     = active && window_hit(base, addr);
  assign data_rd = hit && rd && !addr[0];
  assign data_wr = hit && wr && !addr[0];
  assign stat_rd = hit && rd &&  addr[0];
  assign cmd_wr  = hit && wr &&  addr[0];
endmodule

// File: rtl/midi_byte_fifo.sv
module midi_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];
  assign count   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/midi_host_port.sv
module midi_host_port
  import midi_host_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter logic [15:0] BASE_RST = 16'h0330
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_idx,
  input  logic [7:0]  cfg_wdata,
  input  logic [15:0] io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        irq,
  output logic [7:0]  tx_byte,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic [7:0]  rx_byte,
  input  logic        rx_valid,
  output logic        rx_ready
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic       act_q;
  logic [7:0] base_hi_q;
  logic [7:1] base_lo_q;
  logic       uart_q;
  logic       ack_q;

  logic [15:0] base;
  logic data_rd, data_wr, stat_rd, cmd_wr;
  logic cmd_rst, cmd_uart, cmd_ok;
  logic ack_take, rx_pop, rx_push, tx_pop;
  logic rx_empty, rx_full, tx_empty, tx_full;
  logic [7:0] rx_head;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic avail;

  assign base = {base_hi_q, base_lo_q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      base_hi_q <= BASE_RST[15:8];
      base_lo_q <= BASE_RST[7:1];
    end else if (cfg_wr) begin
      if (cfg_idx == IDX_ENABLE)  act_q     <= cfg_wdata[0];
      if (cfg_idx == IDX_BASE_HI) base_hi_q <= cfg_wdata;
      if (cfg_idx == IDX_BASE_LO) base_lo_q <= cfg_wdata[7:1];
    end
  end

  midi_addr_decode u_dec (
    .active (act_q), .base(base), .addr(io_addr), .rd(io_rd), .wr(io_wr),
    .data_rd(data_rd), .data_wr(data_wr), .stat_rd(stat_rd), .cmd_wr(cmd_wr)
  );

  assign cmd_rst  = cmd_wr && (io_wdata == CMD_RESET);
  assign cmd_uart = cmd_wr && (io_wdata == CMD_UART);
  assign cmd_ok   = cmd_rst || cmd_uart;
  assign ack_take = data_rd && ack_q;
  assign rx_pop   = data_rd && !ack_q && !rx_empty;
  assign rx_ready = !uart_q || !rx_full;
  assign rx_push  = rx_valid && uart_q && !rx_full;
  assign tx_valid = !tx_empty;
  assign tx_pop   = tx_valid && tx_ready;
  assign avail    = ack_q || !rx_empty;
  assign irq      = act_q && avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uart_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      if (cmd_rst)       uart_q <= 1'b0;
      else if (cmd_uart) uart_q <= 1'b1;
      if (cmd_ok)        ack_q  <= 1'b1;
      else if (ack_take) ack_q  <= 1'b0;
    end
  end

  midi_byte_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .flush(cmd_rst), .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full), .count(rx_cnt)
  );

  midi_byte_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(1'b0), .push(data_wr), .din(io_wdata),
    .pop(tx_pop), .dout(tx_byte), .empty(tx_empty), .full(tx_full), .count(tx_cnt)
  );

  always_comb begin
    io_rdata = IDLE_BYTE;
    if (data_rd) begin
      if (ack_q)          io_rdata = ACK_BYTE;
      else if (!rx_empty) io_rdata = rx_head;
    end else if (stat_rd) begin
      io_rdata = status_byte(avail, tx_full);
    end
  end
endmodule

// File: rtl/midi_host_port_chk.sv
module midi_host_port_chk
  import midi_host_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic clk,
  input logic rst_n,
  input logic act_q,
  input logic irq,
  input logic ack_q,
  input logic uart_q,
  input logic data_rd,
  input logic data_wr,
  input logic cmd_rst,
  input logic tx_pop,
  input logic rx_valid,
  input logic [7:0] io_rdata,
  input logic [$clog2(DEPTH):0] rx_cnt,
  input logic [$clog2(DEPTH):0] tx_cnt
);
  localparam int CW = $clog2(DEPTH) + 1;

  a_r3_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !irq);

  a_r6_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && ack_q) |-> (io_rdata == ACK_BYTE));

  a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |=> (rx_cnt == '0 && ack_q && !uart_q));

  a_r8_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (!uart_q && rx_valid) |=> (rx_cnt <= $past(rx_cnt)));

  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH)));

  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_cnt == CW'(DEPTH) && !tx_pop) |=> (tx_cnt == CW'(DEPTH)));

  a_r10_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_q && rx_cnt == '0) |-> !irq);
endmodule

bind midi_host_port midi_host_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_q(act_q), .irq(irq), .ack_q(ack_q),
  .uart_q(uart_q), .data_rd(data_rd), .data_wr(data_wr), .cmd_rst(cmd_rst),
  .tx_pop(tx_pop), .rx_valid(rx_valid), .io_rdata(io_rdata),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt)
);

// File: tb/tb_midi_host_port.sv
module tb_midi_host_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_idx = '0, cfg_wdata = '0;
  logic [15:0] io_addr = '0;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic irq;
  logic [7:0] tx_byte;
  logic tx_valid;
  logic tx_ready = 1'b0;
  logic [7:0] rx_byte = '0;
  logic rx_valid = 1'b0;
  logic rx_ready;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  midi_host_port dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .irq(irq), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  // op codes: 0 cfg write, 1 io write, 2 io read+check, 3 rx byte, 4 irq check, 5 tx take+check
  function automatic logic [39:0] v(input logic [3:0] op, input logic [15:0] a,
                                    input logic [7:0] d, input logic [7:0] e, input logic [3:0] r);
    return {op, a, d, e, r};
  endfunction

  localparam int NV = 42;
  localparam logic [39:0] VEC [NV] = '{
    v(2, 16'h0331, 8'h00, 8'hFF, 4'd3),  // R3 inactive, no decode
    v(4, 16'h0000, 8'h00, 8'h00, 4'd3),  // R3 irq low
    v(0, 16'h0030, 8'h01, 8'h00, 4'd1),  // R1 enable
    v(2, 16'h0331, 8'h00, 8'hBF, 4'd4),  // R4 idle status at default base
    v(3, 16'h0000, 8'h12, 8'h00, 4'd8),  // R8 byte outside UART mode
    v(2, 16'h0331, 8'h00, 8'hBF, 4'd8),  // R8 discarded
    v(1, 16'h0331, 8'h3F, 8'h00, 4'd5),  // R5 enter UART mode
    v(4, 16'h0000, 8'h00, 8'h01, 4'd10), // R10 irq up on ack
    v(2, 16'h0331, 8'h00, 8'h3F, 4'd4),  // R4 byte waiting
    v(2, 16'h0330, 8'h00, 8'hFE, 4'd5),  // R5 ack value
    v(4, 16'h0000, 8'h00, 8'h00, 4'd10), // R10 irq down
    v(3, 16'h0000, 8'h90, 8'h00, 4'd8),
    v(3, 16'h0000, 8'h45, 8'h00, 4'd8),
    v(1, 16'h0331, 8'h3F, 8'h00, 4'd6),  // R6 ack behind buffered data
    v(2, 16'h0330, 8'h00, 8'hFE, 4'd6),  // R6 ack first
    v(2, 16'h0330, 8'h00, 8'h90, 4'd6),
    v(2, 16'h0330, 8'h00, 8'h45, 4'd6),
    v(2, 16'h0330, 8'h00, 8'hFF, 4'd11), // R11 empty read
    v(3, 16'h0000, 8'h77, 8'h00, 4'd8),
    v(3, 16'h0000, 8'h78, 8'h00, 4'd8),
    v(1, 16'h0331, 8'hFF, 8'h00, 4'd7),  // R7 reset command
    v(2, 16'h0330, 8'h00, 8'hFE, 4'd7),
    v(2, 16'h0330, 8'h00, 8'hFF, 4'd7),  // R7 flushed
    v(3, 16'h0000, 8'h55, 8'h00, 4'd5),  // R5 UART mode left
    v(2, 16'h0331, 8'h00, 8'hBF, 4'd5),
    v(0, 16'h0060, 8'h03, 8'h00, 4'd1),  // R1 relocate, odd low byte
    v(0, 16'h0061, 8'h01, 8'h00, 4'd1),
    v(2, 16'h0301, 8'h00, 8'hBF, 4'd1),  // R1 bit 0 masked
    v(2, 16'h0331, 8'h00, 8'hFF, 4'd2),  // R2 old base dead
    v(2, 16'h0303, 8'h00, 8'hFF, 4'd2),  // R2 neighbour
    v(1, 16'h0300, 8'hA5, 8'h00, 4'd9),
    v(1, 16'h0302, 8'h11, 8'h00, 4'd2),  // R2 ignored write
    v(1, 16'h0300, 8'h5A, 8'h00, 4'd9),
    v(5, 16'h0000, 8'h00, 8'hA5, 4'd9),  // R9 order
    v(5, 16'h0000, 8'h00, 8'h5A, 4'd9),
    v(1, 16'h0301, 8'h10, 8'h00, 4'd5),  // R5 unknown command
    v(2, 16'h0301, 8'h00, 8'hBF, 4'd5),
    v(1, 16'h0301, 8'h3F, 8'h00, 4'd3),
    v(0, 16'h0030, 8'h00, 8'h00, 4'd3),  // R3 disable with ack pending
    v(4, 16'h0000, 8'h00, 8'h00, 4'd3),
    v(0, 16'h0030, 8'h01, 8'h00, 4'd10),
    v(4, 16'h0000, 8'h00, 8'h01, 4'd10)
  };

  task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input string req, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk); io_rd = 1'b1; io_addr = a;
    #1 check8(req, "read", io_rdata, exp);
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_byte = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic tx_take(input string req, input logic [7:0] exp);
    @(negedge clk);
    #1 check8(req, "tx_valid", {7'd0, tx_valid}, 8'd1);
    check8(req, "tx_byte", tx_byte, exp);
    tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk);
    #1 check8(req, "irq", {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    check8("R10", "reset irq", {7'd0, irq}, 8'd0);
    check8("R9", "reset tx_valid", {7'd0, tx_valid}, 8'd0);
    check8("R8", "reset rx_ready", {7'd0, rx_ready}, 8'd1);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op; logic [15:0] a; logic [7:0] d, e; string rq;
      {op, a, d, e} = VEC[i][39:4];
      rq = $sformatf("R%0d(vec %0d)", VEC[i][3:0], i);
      case (op)
        4'd0: cfg_write(a[7:0], d);
        4'd1: io_write(a, d);
        4'd2: io_read(rq, a, e);
        4'd3: rx_send(d);
        4'd4: irq_chk(rq, e[0]);
        default: tx_take(rq, e);
      endcase
    end
    io_read("R6", 16'h0300, 8'hFE);

    // R9: fill transmit FIFO past its depth
    for (int i = 0; i < 17; i++) io_write(16'h0300, 8'(8'h10 + i));
    io_read("R4", 16'h0301, 8'hFF);
    for (int i = 0; i < 16; i++) tx_take("R9", 8'(8'h10 + i));
    @(negedge clk); #1 check8("R9", "overflow dropped", {7'd0, tx_valid}, 8'd0);

    // R8: fill receive FIFO, back-pressure, read back
    io_write(16'h0301, 8'h3F);
    io_read("R5", 16'h0300, 8'hFE);
    for (int i = 0; i < 16; i++) rx_send(8'(8'h40 + i));
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'hEE;
    #1 check8("R8", "rx_ready full", {7'd0, rx_ready}, 8'd0);
    @(negedge clk); rx_valid = 1'b0;
    for (int i = 0; i < 16; i++) io_read("R8", 16'h0300, 8'(8'h40 + i));
    io_read("R11", 16'h0300, 8'hFF);

    // R1: reset restores default base and disable
    do_reset();
    io_read("R3", 16'h0331, 8'hFF);
    cfg_write(8'h30, 8'h01);
    io_read("R1", 16'h0331, 8'hBF);
    irq_chk("R10", 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule